// File: doc/BRIEF.md
# SAT Search Decision Engine

This block is the central sequencer of a hardware Boolean satisfiability solver. After a host has loaded a CNF instance into the clause rows, a start pulse makes the engine clear every shared line and then make decisions one at a time. Variables are decided in a fixed order set by their index, where index 0 is the variable that occurs most often. Each decision is held on a per-variable valid/value pair that the base cells forward to the clause rows. The engine then waits until the clause rows stop reporting fresh implications. If they reveal no conflict, it goes on to the next variable.

When a conflict remains after the implications settle, the engine runs a fixed recovery sequence. First it strobes the learned-clause capture for one cycle and samples the backtrack level that the base cells agreed on. Next it clears every variable decided above the chosen level and re-precharges the rows. It then applies the opposite value at that level. Each level keeps a flipped bit. A level whose alternative has already been tried is passed over, and the search moves further down. The engine reports satisfiable when the last level settles cleanly. It reports unsatisfiable when no untried level remains at or below the backtrack level. Both results hold until the next start.

Top module: `sat_decision_engine`

## Requirements
- R1: After reset, busy, sat, unsat, refresh, precharge, ident_cc, clr and asg_vld are all low. A start pulse in the idle state begins a search.
- R2: A search opens with exactly one refresh cycle. In that cycle clr is all ones, and it leaves asg_vld at zero before the first decision.
- R3: The decision at level k is made on variable k (bit k of asg_vld/asg_val). Decisions are therefore made in ascending index, and asg_vld is always a contiguous run of ones from bit 0. A first decision drives value 0. A flipped decision changes an already valid bit from 0 to 1.
- R4: While waiting for implications, the engine stays in the wait state in any cycle where new_impli is high. It leaves only after SETTLE consecutive cycles with new_impli low (SETTLE defaults to 2).
- R5: When the wait ends with conflict low, the engine makes the next decision. At the last level it reports sat instead, with every asg_vld bit set and the assignment left on asg_val.
- R6: When the wait ends with conflict high, ident_cc is high for exactly one cycle. Execution follows, then exactly one precharge cycle, then the decision at the chosen level is applied again.
- R7: The target level is the smaller of bck_lvl (sampled while ident_cc is high) and the current level. If the target has already been flipped, the highest unflipped level below it is chosen, so a jump may skip several levels at once.
- R8: In the execution cycle, clr is high exactly for the variables above the chosen level. During the following precharge cycle, asg_vld holds no bit above that level.
- R9: If every level at or below the target is already flipped, the engine goes straight to unsat without precharging.
- R10: For any instance, the reported result equals the satisfiability of the clauses as found by exhaustive evaluation.
- R11: sat and unsat hold their value while start stays low. A new start pulse drops them and begins a fresh search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search on the loaded instance |
| new_impli | input | 1 | OR of all variables' one-cycle fresh-implication pulses |
| conflict | input | 1 | Some variable carries a conflict |
| bck_lvl | input | LVLW | Highest decision level among variables in the conflict |
| busy | output | 1 | Search in progress |
| refresh | output | 1 | Return all shared lines to their idle levels |
| precharge | output | 1 | Re-precharge the rows after a backtrack |
| ident_cc | output | 1 | Capture the literals of the learned clause |
| clr | output | NVARS | Per-variable clear of stored decision and implication state |
| asg_vld | output | NVARS | Variable k currently holds a decision |
| asg_val | output | NVARS | Value decided on variable k |
| sat | output | 1 | Instance found satisfiable |
| unsat | output | 1 | Instance found unsatisfiable |

## Verification
The bench evaluates instances in two ways. In the eager way, a conflict is raised as soon as a clause is falsified by the decisions so far. This gives ordinary chronological recovery, and the flipped-level walk shows up through instances that contain a variable together with its negation. In the lazy way, conflicts are raised only once every variable holds a decision. The falsified clause then often lies several levels below the current one, so this way tests true backjumps together with their clear masks. Across both ways the fresh-implication pulses last 0, 1 or 2 cycles. This tells a real settle window apart from an engine that acts on the first quiet cycle. Directed instances fix the exact clear vectors and the single-flip unsat path, and a sweep of generated instances is compared with exhaustive evaluation.

// File: rtl/sat_de_pkg.sv
package sat_de_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REFRESH,
    ST_ASSIGN,
    ST_WAIT,
    ST_ANALYZE,
    ST_EXECUTE,
    ST_PRECHARGE,
    ST_SAT,
    ST_UNSAT
  } de_state_e;

endpackage

// File: rtl/sat_de_ctrl.sv
module sat_de_ctrl
  import sat_de_pkg::*;
#(
  parameter int SETTLE = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      new_impli,
  input  logic      conflict,
  input  logic      at_last,
  input  logic      pivot_ok,
  output de_state_e state,
  output logic      ev_refresh,
  output logic      ev_decide,
  output logic      ev_advance,
  output logic      ev_capture,
  output logic      ev_backjump
);

  localparam int QW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [QW-1:0] QLAST = QW'(SETTLE - 1);

  de_state_e state_q, state_d;
  logic [QW-1:0] quiet_q;
  logic wait_done;

  // quiet window: consecutive wait cycles with no fresh implication
  assign wait_done = (state_q == ST_WAIT) && !new_impli && (quiet_q == QLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q <= '0;
    end else if (state_q != ST_WAIT || new_impli) begin
      quiet_q <= '0;
    end else if (quiet_q != QLAST) begin
      quiet_q <= quiet_q + 1'b1;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (start) state_d = ST_REFRESH;
      ST_REFRESH:   state_d = ST_ASSIGN;
      ST_ASSIGN:    state_d = ST_WAIT;
      ST_WAIT: begin
        if (wait_done) begin
          if (conflict)     state_d = ST_ANALYZE;
          else if (at_last) state_d = ST_SAT;
          else              state_d = ST_ASSIGN;
        end
      end
      ST_ANALYZE:   state_d = ST_EXECUTE;
      ST_EXECUTE:   state_d = pivot_ok ? ST_PRECHARGE : ST_UNSAT;
      ST_PRECHARGE: state_d = ST_ASSIGN;
      ST_SAT:       if (start) state_d = ST_REFRESH;
      ST_UNSAT:     if (start) state_d = ST_REFRESH;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state       = state_q;
  assign ev_refresh  = (state_q == ST_REFRESH);
  assign ev_decide   = (state_q == ST_ASSIGN);
  assign ev_advance  = wait_done && !conflict && !at_last;
  assign ev_capture  = (state_q == ST_ANALYZE);
  assign ev_backjump = (state_q == ST_EXECUTE) && pivot_ok;

endmodule

// File: rtl/sat_de_stack.sv
module sat_de_stack #(
  parameter int NVARS = 8,
  parameter int LVLW  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_refresh,
  input  logic             ev_advance,
  input  logic             ev_capture,
  input  logic             ev_backjump,
  input  logic [LVLW-1:0]  bck_lvl,
  output logic [LVLW-1:0]  cur_lvl,
  output logic             cur_flip,
  output logic             at_last,
  output logic             pivot_ok,
  output logic [NVARS-1:0] drop_mask
);

  localparam logic [LVLW-1:0] LAST_LVL = LVLW'(NVARS - 1);

  logic [LVLW-1:0]  lvl_q;
  logic [LVLW-1:0]  tgt_q;
  logic [NVARS-1:0] flip_q;
  logic [LVLW:0]    pivot_res;
  logic [LVLW-1:0]  pivot_lvl;

  // highest level at or below tgt whose alternative is still untried
  function automatic logic [LVLW:0] find_pivot(input logic [NVARS-1:0] fl,
                                               input logic [LVLW-1:0]  tgt);
    logic [LVLW:0] r;
    r = '0;
    for (int i = 0; i < NVARS; i++) begin
      if (LVLW'(i) <= tgt && !fl[i]) r = {1'b1, LVLW'(i)};
    end
    return r;
  endfunction

  // variables whose level lies strictly above lvl
  function automatic logic [NVARS-1:0] above_mask(input logic [LVLW-1:0] lvl);
    logic [NVARS-1:0] m;
    for (int i = 0; i < NVARS; i++) m[i] = (LVLW'(i) > lvl);
    return m;
  endfunction

  assign pivot_res = find_pivot(flip_q, tgt_q);
  assign pivot_ok  = pivot_res[LVLW];
  assign pivot_lvl = pivot_res[LVLW-1:0];
  assign drop_mask = above_mask(pivot_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      tgt_q <= '0;
    end else if (ev_refresh) begin
      lvl_q <= '0;
      tgt_q <= '0;
    end else if (ev_advance) begin
      lvl_q <= lvl_q + 1'b1;
    end else if (ev_capture) begin
      tgt_q <= (bck_lvl < lvl_q) ? bck_lvl : lvl_q;
    end else if (ev_backjump) begin
      lvl_q <= pivot_lvl;
    end
  end

  for (genvar g = 0; g < NVARS; g++) begin : g_flip
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flip_q[g] <= 1'b0;
      else if (ev_refresh)  flip_q[g] <= 1'b0;
      else if (ev_backjump) begin
        if (LVLW'(g) == pivot_lvl) flip_q[g] <= 1'b1;
        else if (drop_mask[g])     flip_q[g] <= 1'b0;
      end
    end
  end

  assign cur_lvl  = lvl_q;
  assign cur_flip = flip_q[lvl_q];
  assign at_last  = (lvl_q == LAST_LVL);

endmodule

// File: rtl/sat_de_assign.sv
module sat_de_assign #(
  parameter int NVARS = 8,
  parameter int LVLW  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_decide,
  input  logic [LVLW-1:0]  cur_lvl,
  input  logic             cur_flip,
  input  logic [NVARS-1:0] clr,
  output logic [NVARS-1:0] asg_vld,
  output logic [NVARS-1:0] asg_val
);

  for (genvar g = 0; g < NVARS; g++) begin : g_var
    logic hit;
    assign hit = ev_decide && (cur_lvl == LVLW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        asg_vld[g] <= 1'b0;
        asg_val[g] <= 1'b0;
      end else if (clr[g]) begin
        asg_vld[g] <= 1'b0;
        asg_val[g] <= 1'b0;
      end else if (hit) begin
        asg_vld[g] <= 1'b1;
        asg_val[g] <= cur_flip;
      end
    end
  end

endmodule

// File: rtl/sat_decision_engine.sv
module sat_decision_engine
  import sat_de_pkg::*;
#(
  parameter int NVARS  = 8,
  parameter int LVLW   = $clog2(NVARS),
  parameter int SETTLE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             new_impli,
  input  logic             conflict,
  input  logic [LVLW-1:0]  bck_lvl,
  output logic             busy,
  output logic             refresh,
  output logic             precharge,
  output logic             ident_cc,
  output logic [NVARS-1:0] clr,
  output logic [NVARS-1:0] asg_vld,
  output logic [NVARS-1:0] asg_val,
  output logic             sat,
  output logic             unsat
);

  de_state_e        fsm_state;
  logic             ev_refresh, ev_decide, ev_advance, ev_capture, ev_backjump;
  logic [LVLW-1:0]  cur_lvl;
  logic             cur_flip, at_last, pivot_ok;
  logic [NVARS-1:0] drop_mask;

  sat_de_ctrl #(.SETTLE(SETTLE)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .new_impli   (new_impli),
    .conflict    (conflict),
    .at_last     (at_last),
    .pivot_ok    (pivot_ok),
    .state       (fsm_state),
    .ev_refresh  (ev_refresh),
    .ev_decide   (ev_decide),
    .ev_advance  (ev_advance),
    .ev_capture  (ev_capture),
    .ev_backjump (ev_backjump)
  );

  sat_de_stack #(.NVARS(NVARS), .LVLW(LVLW)) stack_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_refresh  (ev_refresh),
    .ev_advance  (ev_advance),
    .ev_capture  (ev_capture),
    .ev_backjump (ev_backjump),
    .bck_lvl     (bck_lvl),
    .cur_lvl     (cur_lvl),
    .cur_flip    (cur_flip),
    .at_last     (at_last),
    .pivot_ok    (pivot_ok),
    .drop_mask   (drop_mask)
  );

  // clear everything on refresh, only the dropped levels on a backjump
  assign clr = ev_refresh ? '1 : (ev_backjump ? drop_mask : '0);

  sat_de_assign #(.NVARS(NVARS), .LVLW(LVLW)) assign_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_decide (ev_decide),
    .cur_lvl   (cur_lvl),
    .cur_flip  (cur_flip),
    .clr       (clr),
    .asg_vld   (asg_vld),
    .asg_val   (asg_val)
  );

  assign refresh   = ev_refresh;
  assign precharge = (fsm_state == ST_PRECHARGE);
  assign ident_cc  = ev_capture;
  assign sat       = (fsm_state == ST_SAT);
  assign unsat     = (fsm_state == ST_UNSAT);
  assign busy      = !(fsm_state == ST_IDLE || sat || unsat);

endmodule

// File: rtl/sat_decision_engine_chk.sv
module sat_decision_engine_chk
  import sat_de_pkg::*;
#(
  parameter int NVARS = 8,
  parameter int LVLW  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             new_impli,
  input de_state_e        fsm_state,
  input logic [LVLW-1:0]  cur_lvl,
  input logic             busy,
  input logic             refresh,
  input logic             precharge,
  input logic             ident_cc,
  input logic [NVARS-1:0] clr,
  input logic [NVARS-1:0] asg_vld,
  input logic             sat,
  input logic             unsat
);

  // R1
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && (sat || unsat)) && !(sat && unsat));

  // R2
  refresh_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |-> (&clr) ##1 (asg_vld == '0));

  // R3
  vld_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((NVARS'(asg_vld + 1'b1)) & asg_vld) == '0);

  // R4
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_WAIT && new_impli) |=> (fsm_state == ST_WAIT));

  // R5
  sat_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat) |-> (&asg_vld));

  // R6
  ident_then_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ident_cc |=> (fsm_state == ST_EXECUTE));

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({refresh, precharge, ident_cc}));

  // R8
  prech_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    precharge |-> ((asg_vld >> cur_lvl) <= NVARS'(1)));

  // R9
  unsat_from_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unsat) |-> ($past(fsm_state) == ST_EXECUTE));

  // R11
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat && !start) |=> sat);

endmodule

bind sat_decision_engine sat_decision_engine_chk #(.NVARS(NVARS), .LVLW(LVLW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .new_impli (new_impli),
  .fsm_state (fsm_state),
  .cur_lvl   (cur_lvl),
  .busy      (busy),
  .refresh   (refresh),
  .precharge (precharge),
  .ident_cc  (ident_cc),
  .clr       (clr),
  .asg_vld   (asg_vld),
  .sat       (sat),
  .unsat     (unsat)
);

// File: tb/sat_decision_engine_tb_top.sv
module sat_decision_engine_tb_top;

  localparam int NV   = 8;
  localparam int LW   = 3;
  localparam int MAXC = 32;
  localparam int RUN_LIM = 15000;
  localparam int WD_LIM  = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic new_impli;
  logic conflict;
  logic [LW-1:0] bck_lvl;
  logic busy, refresh, precharge, ident_cc, sat, unsat;
  logic [NV-1:0] clr, asg_vld, asg_val;

  always #10 clk = ~clk;

  sat_decision_engine #(.NVARS(NV), .LVLW(LW), .SETTLE(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .new_impli(new_impli),
    .conflict(conflict), .bck_lvl(bck_lvl), .busy(busy), .refresh(refresh),
    .precharge(precharge), .ident_cc(ident_cc), .clr(clr), .asg_vld(asg_vld),
    .asg_val(asg_val), .sat(sat), .unsat(unsat)
  );

  // ---------------- clause environment ----------------
  logic [NV-1:0] cpos [MAXC];
  logic [NV-1:0] cneg [MAXC];
  int  ncl = 0;
  bit  lazy = 1'b0;
  int  kpulse = 0;
  int  run_id = 0;

  function automatic logic [LW-1:0] top_var(input logic [NV-1:0] m);
    logic [LW-1:0] r = '0;
    for (int i = 0; i < NV; i++) if (m[i]) r = LW'(i);
    return r;
  endfunction

  always_comb begin
    conflict = 1'b0;
    bck_lvl  = '0;
    for (int c = 0; c < MAXC; c++) begin
      if (c < ncl && !conflict) begin
        if ((((cpos[c] & ~(asg_vld & ~asg_val)) | (cneg[c] & ~(asg_vld & asg_val))) == '0)
            && (!lazy || (&asg_vld))) begin
          conflict = 1'b1;
          bck_lvl  = top_var(cpos[c] | cneg[c]);
        end
      end
    end
  end

  logic [NV-1:0] env_prev = '0;
  int pulse_cnt = 0;
  always @(posedge clk) begin
    env_prev <= asg_vld;
    if ((asg_vld & ~env_prev) != '0) pulse_cnt <= kpulse;
    else if (pulse_cnt != 0)         pulse_cnt <= pulse_cnt - 1;
  end
  assign new_impli = (pulse_cnt != 0);

  function automatic bit assign_ok(input logic [NV-1:0] a);
    for (int c = 0; c < MAXC; c++)
      if (c < ncl && (((cpos[c] & a) | (cneg[c] & ~a)) == '0)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit brute_sat();
    for (int a = 0; a < (1 << NV); a++) if (assign_ok(NV'(a))) return 1'b1;
    return 1'b0;
  endfunction

  // ---------------- monitor ----------------
  int seen_id = -1;
  int quiet = 100;
  int r3_bad = 0, r4_bad = 0, n_ident = 0, n_prech = 0, n_clr = 0, n_pre = 0;
  logic [NV-1:0] clr_log [4];
  logic [NV-1:0] pre_log [4];
  logic [NV-1:0] pv = '0, pval = '0;

  always @(negedge clk) begin
    logic [NV-1:0] rise, flip;
    if (seen_id != run_id) begin
      seen_id = run_id;
      r3_bad = 0; r4_bad = 0; n_ident = 0; n_prech = 0; n_clr = 0; n_pre = 0;
    end
    rise = asg_vld & ~pv;
    flip = asg_val & ~pval & pv & asg_vld;
    if ((rise | flip) != '0) begin
      if (quiet < 2) r4_bad++;
      if (!$onehot(rise | flip)) r3_bad++;
      if ((asg_val & rise) != '0) r3_bad++;
    end
    if (((asg_vld + 1'b1) & asg_vld) != '0) r3_bad++;
    if (ident_cc) n_ident++;
    if (precharge) begin
      if (n_pre < 4) pre_log[n_pre] = asg_vld;
      n_pre++;
      n_prech++;
    end
    if (clr != '0 && !refresh) begin
      if (n_clr < 4) clr_log[n_clr] = clr;
      n_clr++;
    end
    quiet = new_impli ? 0 : quiet + 1;
    pv = asg_vld;
    pval = asg_val;
  end

  // ---------------- checking ----------------
  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_cnf();
    ncl = 0;
    for (int c = 0; c < MAXC; c++) begin cpos[c] = '0; cneg[c] = '0; end
  endtask

  task automatic add_clause(input logic [NV-1:0] p, input logic [NV-1:0] n);
    cpos[ncl] = p; cneg[ncl] = n; ncl++;
  endtask

  task automatic gen_cnf(input int count);
    clear_cnf();
    for (int c = 0; c < count; c++) begin
      int w;
      logic [NV-1:0] m, pol;
      w = (($urandom % 8) == 0) ? 1 : 2 + ($urandom % 2);
      m = '0;
      while ($countones(m) < w) m[$urandom % NV] = 1'b1;
      pol = NV'($urandom);
      add_clause(m & pol, m & ~pol);
    end
  endtask

  // start one search and wait for its result; checks R2 and R11 on the way
  task automatic run_cnf(output logic got_sat, output logic got_unsat);
    int cyc = 0;
    run_id++;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!sat && !unsat && busy, "R11", "status after start", {sat, unsat, busy}, 3'b001);
    chk(refresh && (clr == '1), "R2", "refresh clears all", {refresh, clr}, {1'b1, {NV{1'b1}}});
    @(negedge clk);
    chk(asg_vld == '0, "R2", "no decision before refresh done", asg_vld, 0);
    while (!(sat || unsat) && cyc < RUN_LIM) begin
      @(negedge clk); cyc++;
    end
    chk(cyc < RUN_LIM, "R10", "search finished", cyc, RUN_LIM);
    got_sat = sat;
    got_unsat = unsat;
  endtask

  task automatic post_checks(input logic got_sat, input logic got_unsat, input bit exp_sat);
    chk(got_sat == exp_sat && got_unsat == !exp_sat, "R10", "result vs exhaustive",
        {got_sat, got_unsat}, {exp_sat, !exp_sat});
    if (got_sat) begin
      chk((&asg_vld) && assign_ok(asg_val), "R5", "sat assignment satisfies all",
          {asg_vld, asg_val}, {{NV{1'b1}}, asg_val});
    end
    chk(r3_bad == 0, "R3", "decision order/value violations", r3_bad, 0);
    chk(r4_bad == 0, "R4", "decision inside settle window", r4_bad, 0);
    chk(n_ident == n_prech + (got_unsat ? 1 : 0), "R6", "capture vs precharge count",
        n_ident, n_prech + (got_unsat ? 1 : 0));
  endtask

  task automatic main_seq();
    logic s, u;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!busy && !sat && !unsat && !refresh && !precharge && !ident_cc && clr == '0 && asg_vld == '0,
        "R1", "reset outputs", {busy, sat, unsat, refresh, precharge, ident_cc, clr, asg_vld}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !sat && !unsat, "R1", "idle without start", {busy, sat, unsat}, 0);

    // (x0|x1)(x0|!x1): chronological flip then walk over flipped level 1 (R7, R8)
    clear_cnf(); lazy = 1'b0; kpulse = 1;
    add_clause(8'h03, 8'h00);
    add_clause(8'h01, 8'h02);
    run_cnf(s, u);
    post_checks(s, u, 1'b1);
    chk(n_clr == 2 && clr_log[0] == 8'hFC && clr_log[1] == 8'hFE, "R8", "execute clear masks",
        {clr_log[0], clr_log[1]}, 16'hFCFE);
    chk(pre_log[0] == 8'h03 && pre_log[1] == 8'h01, "R7", "kept levels at precharge",
        {pre_log[0], pre_log[1]}, 16'h0301);
    chk(asg_val == 8'h01, "R7", "final values after walk", asg_val, 8'h01);

    // lazy (x1): jump from level 7 straight to level 1 (R7, R8)
    clear_cnf(); lazy = 1'b1; kpulse = 0;
    add_clause(8'h02, 8'h00);
    run_cnf(s, u);
    post_checks(s, u, 1'b1);
    chk(n_clr == 1 && clr_log[0] == 8'hFC, "R8", "backjump clear mask", clr_log[0], 8'hFC);
    chk(pre_log[0] == 8'h03, "R7", "non-chronological target", pre_log[0], 8'h03);
    chk(asg_val == 8'h02, "R7", "values after backjump", asg_val, 8'h02);

    // (x0)(!x0): level 0 already flipped -> unsat (R9)
    clear_cnf(); lazy = 1'b0; kpulse = 2;
    add_clause(8'h01, 8'h00);
    add_clause(8'h00, 8'h01);
    run_cnf(s, u);
    post_checks(s, u, 1'b0);
    chk(n_ident == 2 && n_prech == 1, "R9", "unsat after one flip", {n_ident, n_prech}, {32'd2, 32'd1});
    repeat (5) @(negedge clk);
    chk(unsat && !sat && !busy, "R11", "unsat held", {unsat, sat, busy}, 3'b100);

    // sweep of generated instances
    void'($urandom(32'd12345));
    for (int it = 0; it < 100; it++) begin
      bit exp;
      lazy = (it % 10 == 9);
      kpulse = it % 3;
      gen_cnf(lazy ? 6 + ($urandom % 10) : 3 + ($urandom % 22));
      exp = brute_sat();
      run_cnf(s, u);
      post_checks(s, u, exp);
    end
  endtask

  initial begin
    bit timed_out = 1'b0;
    clear_cnf();
    fork
      main_seq();
      begin
        repeat (WD_LIM) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      tests++;
      fails++;
      $display("FAIL R10 watchdog: actual %0d expected below %0d cycles", WD_LIM, WD_LIM);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule